// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block sequences addresses and data for the read port of a parallel NOR flash that can run in synchronous burst mode. After reset the port acts as a plain asynchronous read path: the word at the presented address appears on the data output with no clock involved. A two-write command sequence switches it into burst mode and programs a mode register. The mode register holds the burst length, the word ordering and the initial latency.

In burst mode, a rising clock edge with the active-low load strobe asserted captures a start address. The latency counter then counts the programmed number of clocks. After that the block delivers one word per clock from its internal array, and a ready output marks each valid beat. Three orderings are supported. Linear order wraps inside an aligned block of 4, 8, 16 or 32 words. Interleaved order flips the low block-index bits. Continuous order walks the whole address range and inserts a one-clock ready bubble when it wraps past the top address.

A new load strobe aborts the running burst and restarts it. Releasing chip enable ends the burst and turns the data drivers off.

Top module: `nor_burst_reader`

## Requirements
- R1: After reset the port is in asynchronous mode. While `ce_n` is low, `dq_out` shows the array word at `addr_in` in the same cycle, and `dq_oe` and `ready` are high. `load_n` has no effect in this mode.
- R2: Burst mode is entered only by a write of code 0xA9 followed directly by a write of code 0x6C. Any other code written in between cancels the arming, and 0x6C written without arming is ignored. A write of code 0xF0 returns the port to asynchronous mode.
- R3: The 7-bit argument of the 0x6C write programs the mode. Bits [1:0] select the length: 0=4, 1=8, 2=16, 3=32 words. Bits [3:2] select the ordering: 0=linear wrap, 1=interleaved, 2 or 3=continuous. Bits [6:4] hold the latency L, where values 0 and 1 act as 2.
- R4: A load at rising edge E drives `ready` low. Word 0 appears with `ready` high after edge E+L, and word k appears after edge E+L+k.
- R5: In linear order with length N, beat k reads the address whose bits above log2(N) equal the start address and whose low bits equal (start+k) mod N.
- R6: In interleaved order, beat k reads the start address with its low log2(N) bits XORed with k.
- R7: Linear and interleaved bursts stop after N beats. `ready` then stays low until the next load.
- R8: In continuous order, beat k reads (start+k) modulo the address range, with no wrap at block boundaries.
- R9: In continuous order, after the beat at the top address `ready` is low for exactly one clock. The next beat then reads address 0.
- R10: A load during a burst aborts it. `ready` is low after that edge, and the new burst follows R4 from the new address.
- R11: With `ce_n` high, `dq_oe` and `ready` are low at once and any burst ends. When `ce_n` goes low again, no data is delivered until a new load.
- R12: The array word at address a is the low 16 bits of (a × 0x9E37) XOR 0x5A5A, for the default 16-bit data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| load_n | input | 1 | Active-low start-address load strobe |
| addr_in | input | AW (10) | Read address / burst start address |
| cmd_we | input | 1 | Command write strobe, one clock per write |
| cmd_code | input | 8 | Command code |
| cmd_arg | input | 7 | Mode argument for the enter command |
| dq_out | output | DW (16) | Read data |
| dq_oe | output | 1 | Data output driver enable |
| ready | output | 1 | High when `dq_out` carries a valid word |

## Verification
Asynchronous reads and chip-enable release act within the same cycle, so those checks sample just after the inputs change. A burst loaded at edge E has its first word due one sample after edge E+L. Each later word is due one edge later, and the wrap bubble in continuous mode adds exactly one extra edge. The bench drives every input on the falling clock edge and samples 1 ns after each rising edge. It counts edges from the load edge, so every expected value is compared in the one cycle where it is due. An abort starts a fresh count from the new load edge.

// File: rtl/nor_burst_pkg.sv
package nor_burst_pkg;

  typedef enum logic [1:0] {
    ORD_LINEAR     = 2'd0,
    ORD_INTERLEAVE = 2'd1,
    ORD_CONT       = 2'd2,
    ORD_CONT_ALT   = 2'd3
  } burst_order_e;

  typedef struct packed {
    logic [2:0]   lat;
    burst_order_e order;
    logic [1:0]   len_code;
  } burst_mode_t;

  localparam logic [7:0] CMD_ARM   = 8'hA9;
  localparam logic [7:0] CMD_ENTER = 8'h6C;
  localparam logic [7:0] CMD_LEAVE = 8'hF0;

  localparam logic [2:0] LAT_MIN = 3'd2;

endpackage

// File: rtl/burst_word_rom.sv
module burst_word_rom #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);

  localparam logic [31:0] MULT = 32'h9E37;
  localparam logic [31:0] SALT = 32'h5A5A;

  // computed array contents: scrambled address pattern
  assign word = (DW'(addr) * DW'(MULT)) ^ DW'(SALT);

endmodule

// File: rtl/burst_mode_ctl.sv
module burst_mode_ctl
  import nor_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [7:0]  cmd_code,
  input  logic [6:0]  cmd_arg,
  output logic        burst_en,
  output burst_mode_t mode
);

  logic        en_q, en_d;
  logic        arm_q, arm_d;
  burst_mode_t mode_q, mode_d;
  burst_mode_t arg_mode;

  always_comb begin
    arg_mode = burst_mode_t'(cmd_arg);
    if (arg_mode.lat < LAT_MIN) arg_mode.lat = LAT_MIN;
  end

  always_comb begin
    en_d   = en_q;
    arm_d  = arm_q;
    mode_d = mode_q;
    if (cmd_we) begin
      arm_d = 1'b0;
      if (cmd_code == CMD_LEAVE) begin
        en_d = 1'b0;
      end else if (cmd_code == CMD_ARM) begin
        arm_d = 1'b1;
      end else if (cmd_code == CMD_ENTER && arm_q) begin
        en_d   = 1'b1;
        mode_d = arg_mode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      arm_q  <= 1'b0;
      mode_q <= '{lat: LAT_MIN, order: ORD_LINEAR, len_code: 2'd0};
    end else if (cmd_we) begin
      en_q   <= en_d;
      arm_q  <= arm_d;
      mode_q <= mode_d;
    end
  end

  assign burst_en = en_q;
  assign mode     = mode_q;

  // R2
  enter_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(arm_q));

  // R3
  lat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.lat >= LAT_MIN);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import nor_burst_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_fire,
  input  logic [AW-1:0] addr_in,
  input  logic [1:0]    len_code,
  input  burst_order_e  order,
  input  logic [AW-1:0] beat_idx,
  output logic [AW-1:0] beat_addr,
  output logic          last_beat,
  output logic          at_top
);

  logic [AW-1:0] start_q;
  logic [AW-1:0] mask;
  logic [AW-1:0] lin_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         start_q <= '0;
    else if (load_fire) start_q <= addr_in;
  end

  assign mask    = AW'((32'd4 << len_code) - 32'd1);
  assign lin_low = (start_q + beat_idx) & mask;

  always_comb begin
    unique case (order)
      ORD_LINEAR:     beat_addr = (start_q & ~mask) | lin_low;
      ORD_INTERLEAVE: beat_addr = start_q ^ (beat_idx & mask);
      default:        beat_addr = start_q + beat_idx;
    endcase
  end

  assign last_beat = ((beat_idx & mask) == mask);
  assign at_top    = &beat_addr;

  // R6
  interleave_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order == ORD_INTERLEAVE) |-> ((beat_addr & ~mask) == (start_q & ~mask)));

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_en,
  input  logic          ce_n,
  input  logic          load_n,
  input  logic          abort,
  input  logic [2:0]    lat,
  input  logic          cont,
  input  logic          last_beat,
  input  logic          at_top,
  input  logic [DW-1:0] word_in,
  output logic          load_fire,
  output logic [AW-1:0] beat_idx,
  output logic          rdy,
  output logic [DW-1:0] dq
);

  logic          active_q, active_d;
  logic [2:0]    wait_q, wait_d;
  logic [AW-1:0] beat_q, beat_d;
  logic          rdy_q, rdy_d;
  logic [DW-1:0] dq_q;
  logic          dq_en;

  always_comb begin
    active_d  = active_q;
    wait_d    = wait_q;
    beat_d    = beat_q;
    rdy_d     = 1'b0;
    dq_en     = 1'b0;
    load_fire = 1'b0;
    if (!burst_en || ce_n || abort) begin
      active_d = 1'b0;
    end else if (!load_n) begin
      load_fire = 1'b1;
      active_d  = 1'b1;
      wait_d    = lat - 3'd1;
      beat_d    = '0;
    end else if (active_q) begin
      if (wait_q != 3'd0) begin
        wait_d = wait_q - 3'd1;
      end else begin
        rdy_d  = 1'b1;
        dq_en  = 1'b1;
        beat_d = beat_q + 1'b1;
        if (!cont && last_beat)   active_d = 1'b0;
        else if (cont && at_top)  wait_d   = 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= 3'd0;
      beat_q   <= '0;
      rdy_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      wait_q   <= wait_d;
      beat_q   <= beat_d;
      rdy_q    <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dq_q <= '0;
    else if (dq_en) dq_q <= word_in;
  end

  assign beat_idx = beat_q;
  assign rdy      = rdy_q;
  assign dq       = dq_q;

  // R4
  ready_after_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> ($past(wait_q) == 3'd0 && $past(active_q)));

  // R7
  stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !active_q) |=> !rdy_q);

  // R10
  reload_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (active_q && !rdy_q && beat_q == '0));

  // R11
  ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !rdy_q);

endmodule

// File: rtl/nor_burst_reader.sv
module nor_burst_reader
  import nor_burst_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          load_n,
  input  logic [AW-1:0] addr_in,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_code,
  input  logic [6:0]    cmd_arg,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          ready
);

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic          burst_en;
  burst_mode_t   mode;
  logic          load_fire;
  logic [AW-1:0] beat_idx;
  logic [AW-1:0] beat_addr;
  logic          last_beat;
  logic          at_top;
  logic [DW-1:0] beat_word;
  logic [DW-1:0] async_word;
  logic          seq_rdy;
  logic [DW-1:0] seq_dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  burst_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_we   (cmd_we),
    .cmd_code (cmd_code),
    .cmd_arg  (cmd_arg),
    .burst_en (burst_en),
    .mode     (mode)
  );

  burst_addr_gen #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_fire (load_fire),
    .addr_in   (addr_in),
    .len_code  (mode.len_code),
    .order     (mode.order),
    .beat_idx  (beat_idx),
    .beat_addr (beat_addr),
    .last_beat (last_beat),
    .at_top    (at_top)
  );

  burst_word_rom #(.AW(AW), .DW(DW)) u_rom_burst (
    .addr (beat_addr),
    .word (beat_word)
  );

  burst_word_rom #(.AW(AW), .DW(DW)) u_rom_async (
    .addr (addr_in),
    .word (async_word)
  );

  burst_seq_ctrl #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .burst_en  (burst_en),
    .ce_n      (ce_n),
    .load_n    (load_n),
    .abort     (cmd_we),
    .lat       (mode.lat),
    .cont      (mode.order[1]),
    .last_beat (last_beat),
    .at_top    (at_top),
    .word_in   (beat_word),
    .load_fire (load_fire),
    .beat_idx  (beat_idx),
    .rdy       (seq_rdy),
    .dq        (seq_dq)
  );

  assign dq_oe  = !ce_n;
  assign ready  = !ce_n && (burst_en ? seq_rdy : 1'b1);
  assign dq_out = burst_en ? seq_dq : async_word;

  // R1
  async_ready_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!burst_en && !ce_n) |-> (ready && dq_out == async_word));

endmodule

// File: tb/test_nor_burst_reader.sv
module test_nor_burst_reader;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n;
  logic        load_n;
  logic [9:0]  addr_in;
  logic        cmd_we;
  logic [7:0]  cmd_code;
  logic [6:0]  cmd_arg;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic        ready;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nor_burst_reader i_nor_burst_reader (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .load_n(load_n), .addr_in(addr_in),
    .cmd_we(cmd_we), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
    .dq_out(dq_out), .dq_oe(dq_oe), .ready(ready)
  );

  // R12 array word
  function automatic logic [15:0] word_of(input logic [9:0] a);
    logic [31:0] p;
    p = {22'd0, a} * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [9:0] exp_addr(input logic [9:0] s, input int lenc,
                                          input int ord, input int k);
    logic [9:0] m;
    m = 10'((4 << lenc) - 1);
    if (ord == 0)      return (s & ~m) | (10'(s + 10'(k)) & m);
    else if (ord == 1) return s ^ (10'(k) & m);
    else               return 10'(s + 10'(k));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] code, input logic [6:0] arg);
    @(negedge clk);
    cmd_we = 1'b1; cmd_code = code; cmd_arg = arg;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic enter_burst(input int lenc, input int ord, input int latc);
    send_cmd(8'hA9, 7'd0);
    send_cmd(8'h6C, {3'(latc), 2'(ord), 2'(lenc)});
  endtask

  task automatic check_beat(input logic [9:0] a, input string req);
    chk(ready === 1'b1 && dq_out === word_of(a), req, {15'd0, ready, dq_out},
        {15'd0, 1'b1, word_of(a)});
  endtask

  task automatic check_idle(input string req);
    chk(ready === 1'b0, req, {31'd0, ready}, 32'd0);
  endtask

  // load at edge E, then check every edge up to E+lat+nbeats+idle-1
  task automatic run_burst(input logic [9:0] start, input int lenc, input int ord,
                           input int lat, input int nbeats, input int idle,
                           input string req);
    @(negedge clk); addr_in = start; load_n = 1'b0;
    @(posedge clk); #1; check_idle(req);
    @(negedge clk); load_n = 1'b1; addr_in = ~start;
    for (int j = 1; j < lat + nbeats + idle; j++) begin
      @(posedge clk); #1;
      if (j < lat)              check_idle(req);
      else if (j < lat + nbeats) check_beat(exp_addr(start, lenc, ord, j - lat), req);
      else                      check_idle(req);
    end
  endtask

  task automatic t_reset;
    chk(dq_oe === 1'b0 && ready === 1'b0, "R1 reset ce_n high", {dq_oe, ready}, 0);
    @(negedge clk); ce_n = 1'b0; addr_in = 10'h123; #1;
    chk(dq_oe === 1'b1, "R1 oe", {31'd0, dq_oe}, 1);
    check_beat(10'h123, "R1 R12 async read");
  endtask

  task automatic t_async_load_ignored;
    @(negedge clk); load_n = 1'b0; addr_in = 10'h2A0;
    @(negedge clk); load_n = 1'b1; addr_in = 10'h077; #1;
    check_beat(10'h077, "R1 load ignored");
    @(posedge clk); #1;
    check_beat(10'h077, "R1 async steady");
  endtask

  task automatic t_bad_sequences;
    send_cmd(8'h6C, 7'h00);
    @(negedge clk); addr_in = 10'h031; #1;
    check_beat(10'h031, "R2 enter without arm");
    send_cmd(8'hA9, 7'h00);
    send_cmd(8'h11, 7'h00);
    send_cmd(8'h6C, 7'h00);
    @(negedge clk); addr_in = 10'h0C4; #1;
    check_beat(10'h0C4, "R2 arm cancelled");
    enter_burst(0, 0, 2);
    @(posedge clk); #1;
    check_idle("R2 burst mode idle");
  endtask

  task automatic t_linear;
    enter_burst(1, 0, 3);
    run_burst(10'h015, 1, 0, 3, 8, 3, "R4 R5 R7 linear len8");
  endtask

  task automatic t_interleave;
    enter_burst(0, 1, 2);
    run_burst(10'h02E, 0, 1, 2, 4, 2, "R6 interleave len4");
    enter_burst(2, 1, 4);
    run_burst(10'h12B, 2, 1, 4, 16, 2, "R6 R7 interleave len16");
  endtask

  task automatic t_long_latency;
    enter_burst(3, 0, 7);
    run_burst(10'h3F3, 3, 0, 7, 32, 2, "R3 R5 len32 lat7");
    enter_burst(0, 0, 0);
    run_burst(10'h242, 0, 0, 2, 4, 2, "R3 lat code0 as 2");
  endtask

  task automatic t_continuous;
    enter_burst(0, 2, 2);
    run_burst(10'h00E, 0, 2, 2, 6, 0, "R8 continuous crosses block");
  endtask

  task automatic t_wrap;
    enter_burst(0, 3, 2);
    @(negedge clk); addr_in = 10'h3FE; load_n = 1'b0;
    @(posedge clk); #1; check_idle("R9 load");
    @(negedge clk); load_n = 1'b1;
    @(posedge clk); #1; check_idle("R9 latency");
    @(posedge clk); #1; check_beat(10'h3FE, "R9 beat 3FE");
    @(posedge clk); #1; check_beat(10'h3FF, "R9 beat top");
    @(posedge clk); #1; check_idle("R9 bubble");
    @(posedge clk); #1; check_beat(10'h000, "R9 beat 0");
    @(posedge clk); #1; check_beat(10'h001, "R9 beat 1");
  endtask

  task automatic t_reload;
    enter_burst(0, 0, 2);
    @(negedge clk); addr_in = 10'h040; load_n = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); load_n = 1'b1;
    @(posedge clk); #1; check_idle("R10 first latency");
    @(posedge clk); #1; check_beat(10'h040, "R10 first beat");
    @(posedge clk); #1; check_beat(10'h041, "R10 second beat");
    run_burst(10'h083, 0, 0, 2, 4, 1, "R10 restart");
  endtask

  task automatic t_chip_enable;
    enter_burst(0, 2, 2);
    @(negedge clk); addr_in = 10'h100; load_n = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); load_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1; check_beat(10'h100, "R11 beat before release");
    @(negedge clk); ce_n = 1'b1; #1;
    chk(dq_oe === 1'b0 && ready === 1'b0, "R11 released", {dq_oe, ready}, 0);
    @(negedge clk); ce_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; check_idle("R11 no data without load");
    end
  endtask

  task automatic t_leave;
    send_cmd(8'hF0, 7'h00);
    @(negedge clk); addr_in = 10'h155; #1;
    check_beat(10'h155, "R2 leave to async");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; load_n = 1'b1; addr_in = '0;
    cmd_we = 1'b0; cmd_code = '0; cmd_arg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_async_load_ignored();
    t_bad_sequences();
    t_linear();
    t_interleave();
    t_long_latency();
    t_continuous();
    t_wrap();
    t_reload();
    t_chip_enable();
    t_leave();
    finish_run();
  end

endmodule